// File: doc/BRIEF.md
# DMA External Request Handshake Controller

This block handles the request/acknowledge exchange between an external device and one DMA channel's transfer engine. The device raises a request line. The controller accepts the request by edge or by level. It answers with a one-cycle request-acknowledge pulse and, after a fixed latency, issues a start command to the bus engine. While a bus cycle runs, the controller drives a transfer-acknowledge strobe. That strobe is placed by addressing mode: it covers the whole cycle for single-address transfers, and either the read half or the write half for dual-address transfers.

The channel has two modes. In burst mode, one accepted request drives a run of back-to-back transfers. In cycle-steal mode, each transfer needs its own accepted request. A transfer counter is loaded while the channel is disabled, counts down once per completed bus cycle, and raises a sticky done flag when it reaches zero. A small built-in bus-cycle model stands in for the real memory bus: it has a read phase and a write phase and reports the end of each cycle. Dropping the channel enable aborts everything.

Top module: `dreq_handshake_ctrl`

## Requirements
- R1: While `chan_en` is low, `drak`, `cyc_start`, `dack` and `done` are low from the next cycle on, and the transfer count is reloaded from `xfer_count`.
- R2: In edge mode (`level_mode`=0) a request is accepted only on a 0-to-1 change of `dreq`; a request held high is not accepted a second time.
- R3: In burst mode with edge detection, one accepted request runs `xfer_count` transfers back to back. Consecutive `cyc_start` pulses are RD_CYC+WR_CYC+1 cycles apart (5 by default), and `drak` pulses once per run.
- R4: `drak` is a one-cycle pulse in the cycle after the accepting sample. The first `cyc_start` after an idle accept comes BURST_LAT cycles (default 5) after the sample in burst mode and STEAL_LAT cycles (default 4) after it in cycle-steal mode.
- R5: In cycle-steal mode, `dreq` is sampled again from the cycle after `cyc_start` while more than one transfer remains; each accepted sample gives one `drak` and exactly one further transfer.
- R6: With `single_addr`=1, `dack` is high in every cycle of every bus cycle (read and write phases both).
- R7: With `single_addr`=0, `dack` is high exactly during the read phase when `ack_on_write`=0 and exactly during the write phase when `ack_on_write`=1.
- R8: In level mode (`level_mode`=1, burst or cycle-steal), negating `dreq` after `drak` suspends the channel once the running bus cycle ends: no further `drak` and no `cyc_start` until `dreq` is high again, after which the remaining transfers complete.
- R9: The count decrements once per completed bus cycle. When it reaches zero, `done` rises and stays high, and no further `cyc_start` occurs while the channel stays enabled, whatever `dreq` does.
- R10: Clearing `chan_en` during the start latency cancels the pending transfer. No `cyc_start` follows, and re-enabling restarts with the full reloaded count.
- R11: In burst mode with edge detection, `dreq` activity after the first accepted sample has no effect on the number of transfers or `drak` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; low aborts and reloads the count |
| burst_mode | input | 1 | 1 = burst, 0 = cycle steal |
| level_mode | input | 1 | 1 = level detection, 0 = rising-edge detection |
| single_addr | input | 1 | 1 = single-address, 0 = dual-address |
| ack_on_write | input | 1 | Dual-address: 0 = acknowledge in read phase, 1 = in write phase |
| xfer_count | input | CNT_W | Number of transfers, loaded while disabled |
| dreq | input | 1 | External transfer request |
| drak | output | 1 | Request-accepted pulse |
| dack | output | 1 | Transfer acknowledge strobe |
| cyc_start | output | 1 | Start command to the bus engine |
| bus_rd | output | 1 | Bus model in read phase |
| bus_wr | output | 1 | Bus model in write phase |
| bus_end | output | 1 | Last cycle of a bus cycle |
| done | output | 1 | Count reached zero |

## Verification
The main function is swept over all sixteen mode combinations (burst/steal, edge/level, single/dual, both acknowledge placements) with counts of one to three. For each case the request line is driven by a device model that fits the mode. In burst-edge mode the line is toggled every cycle after the first acknowledge, which shows whether later edges are wrongly accepted. In cycle-steal edge mode the line is re-pulsed after each start, which shows whether resampling is armed at the right time. In level mode the line is held high, which shows continuation against suspension. Dedicated runs negate the level request after the first acknowledge to expose suspension, hold an edge request high to expose retriggering, and drop the enable inside the start latency to expose a start that leaks through.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_WAIT = 2'd1,
        HS_BUSY = 2'd2,
        HS_DONE = 2'd3
    } hs_state_e;

    typedef enum logic [1:0] {
        BP_IDLE = 2'd0,
        BP_RD   = 2'd1,
        BP_WR   = 2'd2
    } bus_phase_e;

endpackage

// File: rtl/dreq_detect.sv
module dreq_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic dreq,
    input  logic level_mode,
    output logic trig
);
    typedef struct packed {
        logic last;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d      = det_q;
        det_d.last = dreq;
        trig       = level_mode ? dreq : (dreq & ~det_q.last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end
endmodule

// File: rtl/dreq_bus_stub.sv
module dreq_bus_stub
    import dreq_pkg::*;
#(
    parameter int RD_CYC = 2,
    parameter int WR_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic abort,
    input  logic start,
    output logic rd_ph,
    output logic wr_ph,
    output logic cyc_end
);
    localparam int MAXP = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int PH_W = $clog2(MAXP + 1);

    typedef struct packed {
        bus_phase_e      ph;
        logic [PH_W-1:0] left;
    } stub_t;

    stub_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (abort) begin
            s_d.ph   = BP_IDLE;
            s_d.left = '0;
        end else begin
            unique case (s_q.ph)
                BP_IDLE: if (start) begin
                    s_d.ph   = BP_RD;
                    s_d.left = PH_W'(RD_CYC - 1);
                end
                BP_RD: if (s_q.left == '0) begin
                    s_d.ph   = BP_WR;
                    s_d.left = PH_W'(WR_CYC - 1);
                end else begin
                    s_d.left = s_q.left - 1'b1;
                end
                BP_WR: if (s_q.left == '0) begin
                    s_d.ph = BP_IDLE;
                end else begin
                    s_d.left = s_q.left - 1'b1;
                end
                default: s_d.ph = BP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: BP_IDLE, left: '0};
        else        s_q <= s_d;
    end

    assign rd_ph   = (s_q.ph == BP_RD);
    assign wr_ph   = (s_q.ph == BP_WR);
    assign cyc_end = (s_q.ph == BP_WR) && (s_q.left == '0);
endmodule

// File: rtl/dreq_xfer_fsm.sv
module dreq_xfer_fsm
    import dreq_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int BURST_LAT = 5,
    parameter int STEAL_LAT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic             burst_mode,
    input  logic             level_mode,
    input  logic [CNT_W-1:0] xfer_count,
    input  logic             trig,
    input  logic             cyc_end,
    output logic             drak,
    output logic             cyc_start,
    output logic             done
);
    localparam int MAXLAT = (BURST_LAT > STEAL_LAT) ? BURST_LAT : STEAL_LAT;
    localparam int DLY_W  = $clog2(MAXLAT + 1);

    typedef struct packed {
        hs_state_e        state;
        logic [CNT_W-1:0] cnt;
        logic [DLY_W-1:0] dly;
        logic             pend;
        logic             drak;
        logic             start;
        logic             done;
    } ctl_t;

    ctl_t c_d, c_q;
    logic [DLY_W-1:0] lat_load;
    logic             last_xfer;
    logic             steal_arm;

    always_comb begin
        lat_load  = burst_mode ? DLY_W'(BURST_LAT - 1) : DLY_W'(STEAL_LAT - 1);
        last_xfer = (c_q.cnt == CNT_W'(1));
        steal_arm = !burst_mode && (c_q.state == HS_BUSY) && !c_q.start &&
                    !c_q.pend && (c_q.cnt > CNT_W'(1));

        c_d       = c_q;
        c_d.drak  = 1'b0;
        c_d.start = 1'b0;

        if (!chan_en) begin
            c_d.state = HS_IDLE;
            c_d.cnt   = xfer_count;
            c_d.dly   = '0;
            c_d.pend  = 1'b0;
            c_d.done  = 1'b0;
        end else begin
            unique case (c_q.state)
                HS_IDLE: begin
                    if (c_q.cnt == '0) begin
                        c_d.state = HS_DONE;
                        c_d.done  = 1'b1;
                    end else if (trig) begin
                        c_d.state = HS_WAIT;
                        c_d.drak  = 1'b1;
                        c_d.dly   = lat_load;
                    end
                end
                HS_WAIT: begin
                    if (c_q.dly <= DLY_W'(1)) begin
                        c_d.state = HS_BUSY;
                        c_d.start = 1'b1;
                        c_d.dly   = '0;
                    end else begin
                        c_d.dly = c_q.dly - 1'b1;
                    end
                end
                HS_BUSY: begin
                    if (steal_arm && trig) begin
                        c_d.pend = 1'b1;
                        c_d.drak = 1'b1;
                    end
                    if (cyc_end) begin
                        c_d.cnt = c_q.cnt - 1'b1;
                        if (last_xfer) begin
                            c_d.state = HS_DONE;
                            c_d.done  = 1'b1;
                            c_d.pend  = 1'b0;
                        end else if (burst_mode && !level_mode) begin
                            c_d.start = 1'b1;
                        end else if (burst_mode) begin
                            if (trig) begin
                                c_d.start = 1'b1;
                                c_d.drak  = 1'b1;
                            end else begin
                                c_d.state = HS_IDLE;
                            end
                        end else if (c_d.pend) begin
                            c_d.state = HS_WAIT;
                            c_d.dly   = lat_load;
                            c_d.pend  = 1'b0;
                        end else begin
                            c_d.state = HS_IDLE;
                        end
                    end
                end
                HS_DONE: c_d.done = 1'b1;
                default: c_d.state = HS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{state: HS_IDLE, default: '0};
        else        c_q <= c_d;
    end

    assign drak      = c_q.drak;
    assign cyc_start = c_q.start;
    assign done      = c_q.done;
endmodule

// File: rtl/dreq_handshake_ctrl.sv
module dreq_handshake_ctrl #(
    parameter int CNT_W     = 8,
    parameter int BURST_LAT = 5,
    parameter int STEAL_LAT = 4,
    parameter int RD_CYC    = 2,
    parameter int WR_CYC    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic             burst_mode,
    input  logic             level_mode,
    input  logic             single_addr,
    input  logic             ack_on_write,
    input  logic [CNT_W-1:0] xfer_count,
    input  logic             dreq,
    output logic             drak,
    output logic             dack,
    output logic             cyc_start,
    output logic             bus_rd,
    output logic             bus_wr,
    output logic             bus_end,
    output logic             done
);
    logic trig;
    logic start_w;

    dreq_detect u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .dreq       (dreq),
        .level_mode (level_mode),
        .trig       (trig)
    );

    dreq_xfer_fsm #(
        .CNT_W     (CNT_W),
        .BURST_LAT (BURST_LAT),
        .STEAL_LAT (STEAL_LAT)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_en    (chan_en),
        .burst_mode (burst_mode),
        .level_mode (level_mode),
        .xfer_count (xfer_count),
        .trig       (trig),
        .cyc_end    (bus_end),
        .drak       (drak),
        .cyc_start  (start_w),
        .done       (done)
    );

    dreq_bus_stub #(
        .RD_CYC (RD_CYC),
        .WR_CYC (WR_CYC)
    ) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .abort   (!chan_en),
        .start   (start_w),
        .rd_ph   (bus_rd),
        .wr_ph   (bus_wr),
        .cyc_end (bus_end)
    );

    assign cyc_start = start_w;
    assign dack = single_addr ? (bus_rd | bus_wr)
                              : (ack_on_write ? bus_wr : bus_rd);
endmodule

// File: rtl/dreq_handshake_chk.sv
module dreq_handshake_chk (
    input logic clk,
    input logic rst_n,
    input logic chan_en,
    input logic drak,
    input logic dack,
    input logic cyc_start,
    input logic bus_rd,
    input logic bus_wr,
    input logic done
);
    // R1
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (!drak && !cyc_start && !done && !dack));

    // R4
    drak_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drak |=> !drak);

    // R6
    dack_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dack |-> (bus_rd || bus_wr));

    // R7
    phase_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_rd, bus_wr}));

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && chan_en) |=> done);

    // R9
    no_start_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cyc_start);

    // R3
    start_on_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |-> (!bus_rd && !bus_wr));
endmodule

bind dreq_handshake_ctrl dreq_handshake_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_en   (chan_en),
    .drak      (drak),
    .dack      (dack),
    .cyc_start (cyc_start),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .done      (done)
);

// File: tb/dreq_handshake_ctrl_bench.sv
`timescale 1ns/1ps
module dreq_handshake_ctrl_bench;
    localparam int CW   = 8;
    localparam int BLAT = 5;
    localparam int SLAT = 4;
    localparam int RDC  = 2;
    localparam int WRC  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chan_en = 1'b0, burst_mode = 1'b0, level_mode = 1'b0;
    logic single_addr = 1'b0, ack_on_write = 1'b0, dreq = 1'b0;
    logic [CW-1:0] xfer_count = '0;
    logic drak, dack, cyc_start, bus_rd, bus_wr, bus_end, done;

    int checks = 0;
    int errors = 0;
    int tot_st = 0, tot_drak = 0, tot_dack = 0;

    always #10 clk = ~clk;

    dreq_handshake_ctrl #(.CNT_W(CW), .BURST_LAT(BLAT), .STEAL_LAT(SLAT),
                          .RD_CYC(RDC), .WR_CYC(WRC)) u_dreq_handshake_ctrl (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .burst_mode(burst_mode),
        .level_mode(level_mode), .single_addr(single_addr),
        .ack_on_write(ack_on_write), .xfer_count(xfer_count), .dreq(dreq),
        .drak(drak), .dack(dack), .cyc_start(cyc_start), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_end(bus_end), .done(done));

    always @(posedge clk) begin
        if (cyc_start) tot_st++;
        if (drak) tot_drak++;
        if (dack) tot_dack++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(input bit b, input bit l, input bit s, input bit a, input int n);
        int k = 0, ndrak = 0, nst = 0, ndack = 0, bad = 0;
        int fd = -1, fs = -1, ls = -1, gap_bad = 0, st0;
        bit st_prev = 0, expd;
        chan_en = 0; dreq = 0;
        burst_mode = b; level_mode = l; single_addr = s; ack_on_write = a;
        xfer_count = CW'(n);
        repeat (3) @(negedge clk);
        chan_en = 1;
        @(negedge clk);
        dreq = 1;
        while (!done && k < 3000) begin
            @(negedge clk);
            k++;
            if (drak) begin ndrak++; if (fd < 0) fd = k; end
            if (cyc_start) begin
                nst++;
                if (fs < 0) fs = k;
                else if (b && (k - ls) != RDC + WRC + 1) gap_bad++;
                ls = k;
            end
            if (dack) ndack++;
            expd = s ? (bus_rd | bus_wr) : (a ? bus_wr : bus_rd);
            if (dack != expd) bad++;
            if (b && !l) begin
                if (ndrak > 0) dreq = ~dreq;          // R11 toggling ignored
            end else if (!b && !l) begin
                if (drak) dreq = 1'b0;
                else if (st_prev) dreq = 1'b1;
            end
            st_prev = cyc_start;
        end
        chk(done == 1'b1, "R9 done raised", done, 1);
        chk(nst == n, "R9 transfer count", nst, n);
        if (b && !l) chk(ndrak == 1, "R3/R11 single drak in burst-edge", ndrak, 1);
        else         chk(ndrak == n, "R5/R8 drak per accepted sample", ndrak, n);
        if (s) chk(ndack == n * (RDC + WRC), "R6 dack whole cycle", ndack, n * (RDC + WRC));
        else   chk(ndack == n * (a ? WRC : RDC), "R7 dack one phase", ndack, n * (a ? WRC : RDC));
        chk(bad == 0, s ? "R6 dack placement" : "R7 dack placement", bad, 0);
        chk(fs - fd == (b ? BLAT : SLAT) - 1, "R4 start latency", fs - fd, (b ? BLAT : SLAT) - 1);
        if (b) chk(gap_bad == 0, "R3 back-to-back spacing", gap_bad, 0);
        st0 = tot_st;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            dreq = ~dreq;
        end
        chk(tot_st == st0 && done, "R9 no start after done", tot_st - st0, 0);
        dreq = 0;
    endtask

    task automatic suspend_case(input bit b);
        int d0, s0;
        chan_en = 0; dreq = 0;
        burst_mode = b; level_mode = 1; single_addr = 0; ack_on_write = 0;
        xfer_count = CW'(3);
        repeat (3) @(negedge clk);
        d0 = tot_drak; s0 = tot_st;
        chan_en = 1;
        @(negedge clk);
        dreq = 1;
        while (!drak) @(negedge clk);
        dreq = 0;
        repeat (40) @(negedge clk);
        chk(tot_st - s0 == 1, "R8 suspend starts", tot_st - s0, 1);
        chk(tot_drak - d0 == 1, "R8 suspend no drak", tot_drak - d0, 1);
        chk(done == 0, "R8 suspend not done", done, 0);
        dreq = 1;
        for (int i = 0; i < 200 && !done; i++) @(negedge clk);
        chk(tot_st - s0 == 3, "R8 resume completes", tot_st - s0, 3);
        chk(tot_drak - d0 == 3, "R8 resume drak count", tot_drak - d0, 3);
        dreq = 0;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s0, d0, a0;
        repeat (3) @(negedge clk);
        chk(!drak && !dack && !cyc_start && !done, "R1 reset state", drak | dack | cyc_start | done, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk(!drak && !dack && !cyc_start && !done, "R1 disabled idle", drak | dack | cyc_start | done, 0);

        for (int m = 0; m < 16; m++)
            for (int n = 1; n <= 3; n++)
                run_case(m[3], m[2], m[1], m[0], n);

        // R2: held-high edge request in cycle steal is accepted once
        chan_en = 0; dreq = 0;
        burst_mode = 0; level_mode = 0; single_addr = 1; ack_on_write = 0;
        xfer_count = CW'(2);
        repeat (3) @(negedge clk);
        s0 = tot_st; d0 = tot_drak;
        chan_en = 1;
        @(negedge clk);
        dreq = 1;
        repeat (60) @(negedge clk);
        chk(tot_st - s0 == 1, "R2 no retrigger starts", tot_st - s0, 1);
        chk(tot_drak - d0 == 1, "R2 no retrigger drak", tot_drak - d0, 1);
        chk(done == 0, "R2 not done", done, 0);

        suspend_case(1);
        suspend_case(0);

        // R10: abort inside the start latency
        chan_en = 0; dreq = 0;
        burst_mode = 0; level_mode = 0; single_addr = 1;
        xfer_count = CW'(2);
        repeat (3) @(negedge clk);
        chan_en = 1;
        @(negedge clk);
        dreq = 1;
        while (!drak) @(negedge clk);
        @(negedge clk);
        chan_en = 0;
        s0 = tot_st; d0 = tot_drak; a0 = tot_dack;
        repeat (20) @(negedge clk);
        chk(tot_st == s0, "R10 no start after abort", tot_st - s0, 0);
        chk(tot_drak == d0 && tot_dack == a0, "R10 strobes quiet", tot_drak - d0 + tot_dack - a0, 0);
        chk(done == 0, "R1 done low while disabled", done, 0);
        run_case(0, 0, 1, 0, 2);   // R10 reload on re-enable

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule